// File: doc/BRIEF.md
# Multi-Line Reset Controller with Acknowledged Status

This block drives a bank of reset outputs, one per target clock domain, from a small set of 32-bit registers on a plain address/write/read bus. Software writes an assert word to put individual lines into reset or take them out. Each line has its own target clock. A line enters reset at once. It leaves reset only after two edges of its own target clock.

Each line's reset state is carried back into the bus clock domain, and that returned state drives the status registers. A status bit therefore shows the state the target domain has actually reached, not the state software asked for. If a target clock is gated, a release stays pending and the status bit keeps its asserted value until the clock runs again.

Most lines report status inverted: 0 while in reset and 1 once released. A fixed subset, chosen by a build-time mask, reports non-inverted: 1 while in reset. Software compares against that mask.

Top module: `rstctl_top`

## Requirements
- R1: After bus reset every assert bit reads 1, every reset output is 1, and each status word equals the non-inverted mask word. Those are words 0x0000_0604, 0x0000_0300, 0x0000_0040 and 0x0000_0000 for status words 0 to 3, which puts the non-inverted lines at 2, 9, 10, 40, 41 and 70.
- R2: The assert words sit at byte addresses 0x00, 0x04, 0x08 and 0x0C, and the matching status words sit at 0x10, 0x14, 0x18 and 0x1C. Bit n of word m belongs to line 32·m+n, both for the reset output and for the status bit.
- R3: Writing 1 to an assert bit raises that line's reset output right after the write edge. Its status bit still shows the old value one bus clock later and shows the asserted value two bus clocks after the write edge.
- R4: Writing 0 to an assert bit releases the output only after target clock edges. The status bit shows the release no earlier than two bus clocks after the write edge, and within a bounded time while the target clock runs.
- R5: A settled status bit reads 1 when the line is in reset and its mask bit is 1. When the mask bit is 0 it reads 0 while in reset. Once released it reads the inverse of its in-reset value.
- R6: While a line's target clock is stopped, a release leaves that line's output at 1 and its status at the in-reset value. After the clock restarts, the release completes.
- R7: Reading an assert word returns the last value written to it.
- R8: Writes to status addresses or to addresses at 0x20 and above leave every assert word and every status word unchanged. Reads at 0x20 and above return 0.
- R9: Writes to two adjacent words on consecutive cycles, low word first, each update only their own word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus reset, asynchronous, active low |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| tgt_clk | input | N_WORDS*32 | Target clock, one per line |
| rst_out | output | N_WORDS*32 | Reset output, one per line, 1 = in reset |

## Verification
A stuck or wrongly reset synchroniser flop shows up directly as a status word that differs from the mask-derived expected value. It appears either right after reset or within a few cycles of a write, because every status change has a fixed two-cycle return path. A release path that skips the target domain shows up as a status change while that line's clock is gated. A bad word decode shows up as a wrong bit of rst_out or of a read word on the first access to that word.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    SPACE_ASSERT = 2'd0,
    SPACE_STATUS = 2'd1,
    SPACE_NONE   = 2'd2
  } space_e;

  // Which register bank a byte address falls into.
  function automatic space_e space_of(input logic [31:0] a, input int unsigned words);
    int unsigned w;
    w = a >> 2;
    if (w < words) return SPACE_ASSERT;
    if (w < 2 * words) return SPACE_STATUS;
    return SPACE_NONE;
  endfunction

  // Word slot within a bank.
  function automatic int unsigned slot_of(input logic [31:0] a, input int unsigned words);
    int unsigned w;
    w = a >> 2;
    return w % words;
  endfunction
endpackage

// File: rtl/rstctl_regs.sv
module rstctl_regs
  import rstctl_pkg::*;
#(
  parameter int unsigned N_WORDS = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr_en,
  input  logic [WORD_W-1:0]           wdata,
  input  logic [N_WORDS*WORD_W-1:0]   status_in,
  output logic [N_WORDS*WORD_W-1:0]   assert_q,
  output logic [WORD_W-1:0]           rdata
);
  localparam int unsigned LINES = N_WORDS * WORD_W;

  logic [31:0]        addr_ext;
  space_e             space;
  int unsigned        slot;
  logic [N_WORDS-1:0] wr_hit;
  logic               wr_any;
  logic [LINES-1:0]   assert_d;

  assign addr_ext = 32'(addr);
  assign space    = space_of(addr_ext, N_WORDS);
  assign slot     = slot_of(addr_ext, N_WORDS);

  // decode of writes into the assert bank
  always_comb begin
    wr_hit = '0;
    for (int unsigned w = 0; w < N_WORDS; w++) begin
      wr_hit[w] = wr_en && (space == SPACE_ASSERT) && (slot == w);
    end
  end
  assign wr_any = |wr_hit;

  // next state
  always_comb begin
    assert_d = assert_q;
    for (int unsigned w = 0; w < N_WORDS; w++) begin
      if (wr_hit[w]) assert_d[w*WORD_W +: WORD_W] = wdata;
    end
  end

  // register, all lines start in reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      assert_q <= '1;
    end else if (wr_any) begin
      assert_q <= assert_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    for (int unsigned w = 0; w < N_WORDS; w++) begin
      if (slot == w) begin
        if (space == SPACE_ASSERT) rdata = assert_q[w*WORD_W +: WORD_W];
        if (space == SPACE_STATUS) rdata = status_in[w*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/rstctl_line.sv
module rstctl_line (
  input  logic bus_clk,
  input  logic bus_rst_n,
  input  logic req,
  input  logic tgt_clk,
  output logic rst_out,
  output logic ack
);
  logic       rel_n;
  logic [1:0] tsync_q;
  logic [1:0] tsync_d;
  logic [1:0] bsync_q;
  logic [1:0] bsync_d;

  assign rel_n = ~req;

  // target side: set at once by the request, cleared by two target edges
  assign tsync_d = {tsync_q[0], 1'b0};

  always_ff @(posedge tgt_clk or negedge rel_n) begin
    if (!rel_n) begin
      tsync_q <= 2'b11;
    end else begin
      tsync_q <= tsync_d;
    end
  end

  assign rst_out = tsync_q[1];

  // return path into the bus clock
  assign bsync_d = {bsync_q[0], rst_out};

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      bsync_q <= 2'b11;
    end else begin
      bsync_q <= bsync_d;
    end
  end

  assign ack = bsync_q[1];
endmodule

// File: rtl/rstctl_status.sv
module rstctl_status #(
  parameter int unsigned      LINES   = 128,
  parameter logic [LINES-1:0] HI_MASK = '0
) (
  input  logic [LINES-1:0] ack,
  output logic [LINES-1:0] status
);
  for (genvar i = 0; i < LINES; i++) begin : g_bit
    if (HI_MASK[i]) begin : g_plain
      assign status[i] = ack[i];
    end else begin : g_inv
      assign status[i] = ~ack[i];
    end
  end
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int unsigned              N_WORDS = 4,
  parameter int unsigned              ADDR_W  = 8,
  parameter logic [N_WORDS*32-1:0]    HI_MASK = {32'h0000_0000, 32'h0000_0040,
                                                 32'h0000_0300, 32'h0000_0604}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_en,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  input  logic [N_WORDS*32-1:0]   tgt_clk,
  output logic [N_WORDS*32-1:0]   rst_out
);
  localparam int unsigned LINES = N_WORDS * WORD_W;

  logic [LINES-1:0] assert_q;
  logic [LINES-1:0] ack_w;
  logic [LINES-1:0] status_w;

  rstctl_regs #(
    .N_WORDS (N_WORDS),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .status_in (status_w),
    .assert_q  (assert_q),
    .rdata     (rdata)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    rstctl_line u_line (
      .bus_clk   (clk),
      .bus_rst_n (rst_n),
      .req       (assert_q[i]),
      .tgt_clk   (tgt_clk[i]),
      .rst_out   (rst_out[i]),
      .ack       (ack_w[i])
    );
  end

  rstctl_status #(
    .LINES   (LINES),
    .HI_MASK (HI_MASK)
  ) u_status (
    .ack    (ack_w),
    .status (status_w)
  );
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
  parameter int unsigned N_WORDS = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     addr,
  input logic                  wr_en,
  input logic [31:0]           wdata,
  input logic [N_WORDS*32-1:0] assert_q,
  input logic [N_WORDS*32-1:0] ack_w,
  input logic [N_WORDS*32-1:0] rst_out
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> ((&assert_q) && (&ack_w) && (&rst_out)));

  // R3
  assert_reaches_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((assert_q & ~rst_out) == '0));

  // R4
  ack_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ack_w) & ~ack_w & $past(rst_out, 2)) == '0));

  // R8
  stray_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(addr) >= 32'(N_WORDS * 4))) |=> $stable(assert_q));

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    // R7
    word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ((32'(addr) >> 2) == 32'(w))) |=> (assert_q[w*32 +: 32] == $past(wdata)));
  end
endmodule

bind rstctl_top rstctl_chk #(
  .N_WORDS (N_WORDS),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .wdata    (wdata),
  .assert_q (assert_q),
  .ack_w    (ack_w),
  .rst_out  (rst_out)
);

// File: tb/test_rstctl_top.sv
module test_rstctl_top;
  localparam logic [127:0] HI = {32'h0000_0000, 32'h0000_0040, 32'h0000_0300, 32'h0000_0604};

  logic         clk;
  logic         tclk;
  logic         rst_n;
  logic [7:0]   addr;
  logic         wr_en;
  logic [31:0]  wdata;
  logic [31:0]  rdata;
  logic [127:0] tgt_en;
  logic [127:0] tgt_clk;
  logic [127:0] rst_out;

  int total;
  int bad;
  bit done;
  logic [31:0] model [4];

  assign tgt_clk = tgt_en & {128{tclk}};

  rstctl_top i_rstctl_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .tgt_clk (tgt_clk),
    .rst_out (rst_out)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  initial begin
    tclk = 1'b0;
    forever #4 tclk = ~tclk;
  end

  function automatic logic [31:0] exp_status(input int w, input logic [31:0] a);
    return ~(a ^ HI[w*32 +: 32]);
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle();
    repeat (25) @(posedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int w = 0; w < 4; w++) begin
      bus_read(8'(w * 4), d);
      chk({tag, " R7 assert readback"}, 128'(d), 128'(model[w]));
      bus_read(8'(16 + w * 4), d);
      chk({tag, " R5 status"}, 128'(d), 128'(exp_status(w, model[w])));
      chk({tag, " R2 rst_out word"}, 128'(rst_out[w*32 +: 32]), 128'(model[w]));
    end
  endtask

  initial begin
    logic [31:0] d;
    int cnt;
    total  = 0;
    bad    = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    addr   = '0;
    wr_en  = 1'b0;
    wdata  = '0;
    tgt_en = '1;
    void'($urandom(32'd20240611));
    for (int w = 0; w < 4; w++) model[w] = 32'hFFFF_FFFF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 rst_out", rst_out, '1);
    for (int w = 0; w < 4; w++) begin
      bus_read(8'(w * 4), d);
      chk("R1 assert word", 128'(d), 128'(32'hFFFF_FFFF));
      bus_read(8'(16 + w * 4), d);
      chk("R1 status word", 128'(d), 128'(HI[w*32 +: 32]));
    end

    // R9 split write, low then high, consecutive cycles
    @(negedge clk);
    addr = 8'h00; wdata = 32'h0000_0000; wr_en = 1'b1;
    @(negedge clk);
    addr = 8'h04; wdata = 32'hA5A5_0F0F;
    @(negedge clk);
    wr_en = 1'b0;
    model[0] = 32'h0000_0000;
    model[1] = 32'hA5A5_0F0F;
    bus_read(8'h00, d);
    chk("R9 low word", 128'(d), 128'(model[0]));
    bus_read(8'h04, d);
    chk("R9 high word", 128'(d), 128'(model[1]));

    // R2 single line in word 2
    bus_write(8'h08, 32'hFFFF_FFDF);
    model[2] = 32'hFFFF_FFDF;
    settle();
    chk("R2 line 69 released", 128'(rst_out[69]), 128'(0));
    chk("R2 line 68 held", 128'(rst_out[68]), 128'(1));
    bus_read(8'h18, d);
    chk("R2 status word 2", 128'(d), 128'(exp_status(2, model[2])));
    check_all("directed");

    // R3 assert timing on line 0 (inverted, released now)
    @(negedge clk);
    addr = 8'h00; wdata = model[0] | 32'h1; wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0; addr = 8'h10;
    model[0] = model[0] | 32'h1;
    chk("R3 out raised", 128'(rst_out[0]), 128'(1));
    @(posedge clk);
    #1;
    chk("R3 status holds one cycle", 128'(rdata[0]), 128'(1));
    @(posedge clk);
    #1;
    chk("R3 status after two cycles", 128'(rdata[0]), 128'(0));

    // R4 release timing on line 0
    @(negedge clk);
    addr = 8'h00; wdata = model[0] & ~32'h1; wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0; addr = 8'h10;
    model[0] = model[0] & ~32'h1;
    chk("R4 out still held", 128'(rst_out[0]), 128'(1));
    cnt = 0;
    while (rdata[0] !== 1'b1 && cnt < 40) begin
      @(posedge clk);
      #1;
      cnt++;
    end
    chk("R4 status released", 128'(rdata[0]), 128'(1));
    chk("R4 not before two cycles", 128'(cnt >= 2), 128'(1));
    chk("R4 out released", 128'(rst_out[0]), 128'(0));

    // R6 gated target clocks: line 100 (inverted), line 70 (non-inverted)
    tgt_en[100] = 1'b0;
    tgt_en[70]  = 1'b0;
    bus_write(8'h0C, 32'hFFFF_FFEF);
    model[3] = 32'hFFFF_FFEF;
    bus_write(8'h08, model[2] & ~32'h40);
    model[2] = model[2] & ~32'h40;
    repeat (50) @(posedge clk);
    chk("R6 line 100 held", 128'(rst_out[100]), 128'(1));
    chk("R6 line 70 held", 128'(rst_out[70]), 128'(1));
    bus_read(8'h1C, d);
    chk("R6 status 100 in-reset", 128'(d[4]), 128'(0));
    bus_read(8'h18, d);
    chk("R6 status 70 in-reset", 128'(d[6]), 128'(1));
    @(negedge tclk);
    tgt_en[100] = 1'b1;
    tgt_en[70]  = 1'b1;
    @(negedge clk);
    addr = 8'h1C;
    cnt = 0;
    while (rdata[4] !== 1'b1 && cnt < 40) begin
      @(posedge clk);
      #1;
      cnt++;
    end
    chk("R6 status 100 after restart", 128'(rdata[4]), 128'(1));
    settle();
    bus_read(8'h18, d);
    chk("R6 status 70 after restart", 128'(d[6]), 128'(0));
    check_all("gated");

    // R8 stray writes and unmapped reads
    bus_write(8'h10, 32'h1234_5678);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_write(8'h24, 32'h0000_0000);
    bus_write(8'hFC, 32'h0000_0000);
    settle();
    check_all("R8 after stray writes");
    bus_read(8'h24, d);
    chk("R8 unmapped read 0x24", 128'(d), 128'(0));
    bus_read(8'h80, d);
    chk("R8 unmapped read 0x80", 128'(d), 128'(0));

    // random traffic, R2 R5 R7
    for (int it = 0; it < 40; it++) begin
      int w;
      logic [31:0] v;
      w = int'($urandom % 4);
      v = $urandom;
      bus_write(8'(w * 4), v);
      model[w] = v;
      if (($urandom % 4) == 0) begin
        bus_write(8'(16 + ($urandom % 4) * 4), $urandom);
      end
      settle();
      check_all("random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule